// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers every reset request in a device and turns it into one of three nested reset flows. A power-on input resets the block itself and starts the widest flow. Hard-class requests come from the sensed hard reset pin, a watchdog expiry or a bus-monitor expiry. Soft-class requests come from the sensed soft reset pin or a reset command from the test port. Each flow drives open-drain style hard and soft reset lines, given as drive enables, together with a core reset. Flows that rebuild configuration also issue sampling strobes.

Classes are ranked power-on, then hard, then soft. A higher-class request that arrives during a lower-class flow restarts the sequence as the higher class. A request of the same or a lower class than the running flow is dropped. A hard flow holds the hard line for `HARD_CYC` clocks and then releases it. The soft line and the core reset stay asserted for `GAP_CYC` further clocks. A soft flow holds only the soft line and the core reset, for `SOFT_CYC` clocks. It produces no strobe.

A six-bit sticky status word records which sources caused the reset flows accepted since it was last cleared. Software clears bits by writing ones through a clear port.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por` is high, `hard_drive_en`, `soft_drive_en` and `core_rst` are all 1, and `rst_status` reads 6'b000001.
- R2: After `por` falls, `hard_drive_en` stays high for exactly `HARD_CYC` cycles (default 16). `soft_drive_en` and `core_rst` stay high for `GAP_CYC` cycles beyond that (default 4), so 20 cycles in all. Then everything is low.
- R3: `cfg_por_sample` is high for exactly one cycle per power-on flow, in the second cycle of the hard hold. A hard or soft flow never raises it.
- R4: `cfg_hard_sample` is high for exactly one cycle in the second hold cycle of every power-on or hard flow. A soft flow never raises it.
- R5: A high `soft_sense` while no reset is being driven starts a soft flow. `soft_drive_en` and `core_rst` are high for `SOFT_CYC` cycles (default 8), and `hard_drive_en` stays low.
- R6: `soft_sense` seen while the block is driving any reset is ignored. It does not lengthen the flow and does not set status bit 2.
- R7: `wdog_zero` with `wdog_en` high starts a hard flow when no hard-class flow is running. The same holds for `bmon_zero` with `bmon_en`. Without its enable, an expiry has no effect.
- R8: A high `host_rst_cmd` while no reset is being driven starts a soft flow.
- R9: A hard-class request during a soft flow restarts the sequence as a full hard flow. A hard-class request during a power-on or hard flow, including its gap, is ignored.
- R10: `soft_drive_en` is high in every cycle in which `hard_drive_en` is high.
- R11: The status bits are [0] power-on, [1] hard pin, [2] soft pin, [3] watchdog, [4] bus monitor, [5] host command. A bit is set when that source's request is accepted and stays set. Soft-class sources in the same cycle as an accepted hard request are not recorded.
- R12: With `sts_clr_we` high, every bit that is 1 in `sts_clr_mask` is cleared, unless the same bit is being set in that cycle. A power-on clears every bit except bit 0.
- R13: `hard_sense` is treated as an external hard request only while the block is not driving `hard_drive_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; also resets the block |
| hard_sense | input | 1 | Sensed level of the hard reset line, 1 = asserted |
| soft_sense | input | 1 | Sensed level of the soft reset line, 1 = asserted |
| wdog_zero | input | 1 | Watchdog count reached zero |
| wdog_en | input | 1 | Watchdog reset enable |
| bmon_zero | input | 1 | Bus-monitor count reached zero |
| bmon_en | input | 1 | Bus-monitor reset enable |
| host_rst_cmd | input | 1 | Reset command from the test port |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 6 | Write-one-to-clear mask for the status bits |
| hard_drive_en | output | 1 | Pull-down enable for the hard reset line |
| soft_drive_en | output | 1 | Pull-down enable for the soft reset line |
| core_rst | output | 1 | Reset to the processing cores |
| cfg_hard_sample | output | 1 | One-cycle strobe to capture the hard reset configuration word |
| cfg_por_sample | output | 1 | One-cycle strobe to capture power-on-only configuration |
| rst_status | output | 6 | Sticky record of reset causes |

## Verification
The hardest case to reach is a class restart. A hard-class request has to land a few cycles into a running soft flow, and a second hard-class request has to land inside an active hard hold. The bench times a test-port command and then an external hard pin pulse three cycles later. It also fires the watchdog five cycles into a bus-monitor flow. Both reset lines are looped back as open-drain wires, so the block always senses its own drive. This checks that self-driven levels never count as external requests. A behavioural model runs alongside and is compared with the design on every cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_SOFT = 2'd1,
    CLS_HARD = 2'd2,
    CLS_POR  = 2'd3
  } rst_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_HOLD_HARD = 2'd1,
    PH_GAP       = 2'd2,
    PH_HOLD_SOFT = 2'd3
  } rst_ph_e;

  localparam int SRC_N    = 6;
  localparam int SRC_POR  = 0;
  localparam int SRC_HPIN = 1;
  localparam int SRC_SPIN = 2;
  localparam int SRC_WDOG = 3;
  localparam int SRC_BMON = 4;
  localparam int SRC_HOST = 5;

endpackage

// File: rtl/rst_src_arb.sv
module rst_src_arb
  import rst_seq_pkg::*;
(
  input  rst_cls_e             cur_cls,
  input  logic                 hard_driving,
  input  logic                 hard_sense,
  input  logic                 soft_sense,
  input  logic                 wdog_zero,
  input  logic                 wdog_en,
  input  logic                 bmon_zero,
  input  logic                 bmon_en,
  input  logic                 host_cmd,
  output logic                 req_valid,
  output rst_cls_e             req_cls,
  output logic [SRC_N-1:0]     req_src
);

  logic [SRC_N-1:0] hard_vec;
  logic [SRC_N-1:0] soft_vec;

  always_comb begin
    hard_vec = '0;
    soft_vec = '0;
    // own drive on the line is not an outside request
    hard_vec[SRC_HPIN] = hard_sense && !hard_driving;
    hard_vec[SRC_WDOG] = wdog_zero && wdog_en;
    hard_vec[SRC_BMON] = bmon_zero && bmon_en;
    soft_vec[SRC_SPIN] = soft_sense;
    soft_vec[SRC_HOST] = host_cmd;

    req_valid = 1'b0;
    req_cls   = CLS_NONE;
    req_src   = '0;
    if ((cur_cls == CLS_NONE || cur_cls == CLS_SOFT) && (|hard_vec)) begin
      req_valid = 1'b1;
      req_cls   = CLS_HARD;
      req_src   = hard_vec;
    end else if (cur_cls == CLS_NONE && (|soft_vec)) begin
      req_valid = 1'b1;
      req_cls   = CLS_SOFT;
      req_src   = soft_vec;
    end
  end

endmodule

// File: rtl/rst_flow_seq.sv
module rst_flow_seq
  import rst_seq_pkg::*;
#(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 8,
  parameter int GAP_CYC  = 4
) (
  input  logic     clk,
  input  logic     por,
  input  logic     start,
  input  rst_cls_e start_cls,
  output rst_cls_e cls_o,
  output logic     hard_o,
  output logic     soft_o,
  output logic     core_o,
  output logic     smp_hard_o,
  output logic     smp_por_o
);

  localparam int MAXC = (HARD_CYC > SOFT_CYC)
                      ? ((HARD_CYC > GAP_CYC) ? HARD_CYC : GAP_CYC)
                      : ((SOFT_CYC > GAP_CYC) ? SOFT_CYC : GAP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HARD_LAST = CW'(HARD_CYC - 1);
  localparam logic [CW-1:0] SOFT_LAST = CW'(SOFT_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

  rst_cls_e       cls_q, cls_d;
  rst_ph_e        ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           first_hold;

  always_comb begin
    cls_d = cls_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_HOLD_HARD: begin
        if (cnt_q == HARD_LAST) begin
          ph_d  = PH_GAP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_GAP: begin
        if (cnt_q == GAP_LAST) begin
          ph_d  = PH_IDLE;
          cls_d = CLS_NONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD_SOFT: begin
        if (cnt_q == SOFT_LAST) begin
          ph_d  = PH_IDLE;
          cls_d = CLS_NONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (start) begin
      cnt_d = '0;
      cls_d = start_cls;
      ph_d  = (start_cls == CLS_SOFT) ? PH_HOLD_SOFT : PH_HOLD_HARD;
    end
  end

  assign first_hold = (ph_q == PH_HOLD_HARD) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (por) begin
      cls_q      <= CLS_POR;
      ph_q       <= PH_HOLD_HARD;
      cnt_q      <= '0;
      hard_o     <= 1'b1;
      soft_o     <= 1'b1;
      core_o     <= 1'b1;
      smp_hard_o <= 1'b0;
      smp_por_o  <= 1'b0;
    end else begin
      cls_q      <= cls_d;
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      hard_o     <= (ph_d == PH_HOLD_HARD);
      soft_o     <= (ph_d != PH_IDLE);
      core_o     <= (ph_d != PH_IDLE);
      smp_hard_o <= first_hold && (cls_q != CLS_SOFT);
      smp_por_o  <= first_hold && (cls_q == CLS_POR);
    end
  end

  assign cls_o = cls_q;

endmodule

// File: rtl/rst_sts_reg.sv
module rst_sts_reg
  import rst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic [SRC_N-1:0] set_vec,
  input  logic             clr_we,
  input  logic [SRC_N-1:0] clr_mask,
  output logic [SRC_N-1:0] sts
);

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por) begin
        sts[i] <= (i == SRC_POR);
      end else if (set_vec[i]) begin
        sts[i] <= 1'b1;
      end else if (clr_we && clr_mask[i]) begin
        sts[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 8,
  parameter int GAP_CYC  = 4
) (
  input  logic             clk,
  input  logic             por,
  input  logic             hard_sense,
  input  logic             soft_sense,
  input  logic             wdog_zero,
  input  logic             wdog_en,
  input  logic             bmon_zero,
  input  logic             bmon_en,
  input  logic             host_rst_cmd,
  input  logic             sts_clr_we,
  input  logic [SRC_N-1:0] sts_clr_mask,
  output logic             hard_drive_en,
  output logic             soft_drive_en,
  output logic             core_rst,
  output logic             cfg_hard_sample,
  output logic             cfg_por_sample,
  output logic [SRC_N-1:0] rst_status
);

  rst_cls_e         cur_cls;
  rst_cls_e         req_cls;
  logic             req_valid;
  logic [SRC_N-1:0] req_src;

  rst_src_arb u_arb (
    .cur_cls      (cur_cls),
    .hard_driving (hard_drive_en),
    .hard_sense   (hard_sense),
    .soft_sense   (soft_sense),
    .wdog_zero    (wdog_zero),
    .wdog_en      (wdog_en),
    .bmon_zero    (bmon_zero),
    .bmon_en      (bmon_en),
    .host_cmd     (host_rst_cmd),
    .req_valid    (req_valid),
    .req_cls      (req_cls),
    .req_src      (req_src)
  );

  rst_flow_seq #(
    .HARD_CYC (HARD_CYC),
    .SOFT_CYC (SOFT_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk        (clk),
    .por        (por),
    .start      (req_valid),
    .start_cls  (req_cls),
    .cls_o      (cur_cls),
    .hard_o     (hard_drive_en),
    .soft_o     (soft_drive_en),
    .core_o     (core_rst),
    .smp_hard_o (cfg_hard_sample),
    .smp_por_o  (cfg_por_sample)
  );

  rst_sts_reg u_sts (
    .clk      (clk),
    .por      (por),
    .set_vec  (req_src),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr_mask),
    .sts      (rst_status)
  );

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
  import rst_seq_pkg::*;
(
  input logic             clk,
  input logic             por,
  input logic             hard_sense,
  input logic             soft_sense,
  input logic             wdog_zero,
  input logic             wdog_en,
  input logic             sts_clr_we,
  input logic [SRC_N-1:0] sts_clr_mask,
  input logic             hard_drive_en,
  input logic             soft_drive_en,
  input logic             core_rst,
  input logic             cfg_hard_sample,
  input logic             cfg_por_sample,
  input logic [SRC_N-1:0] rst_status
);

  assert_soft_covers_hard_R10: assert property (@(posedge clk) disable iff (por)
    hard_drive_en |-> soft_drive_en);

  assert_gap_after_hard_R2: assert property (@(posedge clk) disable iff (por)
    $fell(hard_drive_en) |-> soft_drive_en);

  assert_por_strobe_single_R3: assert property (@(posedge clk) disable iff (por)
    cfg_por_sample |=> !cfg_por_sample);

  assert_hard_strobe_in_hold_R4: assert property (@(posedge clk) disable iff (por)
    cfg_hard_sample |-> hard_drive_en);

  assert_idle_soft_pin_R5: assert property (@(posedge clk) disable iff (por)
    (!core_rst && soft_sense) |=> soft_drive_en);

  assert_wdog_promote_R7: assert property (@(posedge clk) disable iff (por)
    (!soft_drive_en && wdog_zero && wdog_en) |=> hard_drive_en);

  assert_ext_hard_pin_R13: assert property (@(posedge clk) disable iff (por)
    (!soft_drive_en && hard_sense) |=> hard_drive_en);

  assert_sticky_bits_R11: assert property (@(posedge clk) disable iff (por)
    !$past(por) |-> ((($past(rst_status) & ~rst_status)
                      & ~($past(sts_clr_we) ? $past(sts_clr_mask) : {SRC_N{1'b0}}))
                     == {SRC_N{1'b0}}));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk             (clk),
  .por             (por),
  .hard_sense      (hard_sense),
  .soft_sense      (soft_sense),
  .wdog_zero       (wdog_zero),
  .wdog_en         (wdog_en),
  .sts_clr_we      (sts_clr_we),
  .sts_clr_mask    (sts_clr_mask),
  .hard_drive_en   (hard_drive_en),
  .soft_drive_en   (soft_drive_en),
  .core_rst        (core_rst),
  .cfg_hard_sample (cfg_hard_sample),
  .cfg_por_sample  (cfg_por_sample),
  .rst_status      (rst_status)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;

  localparam int HC = 16;
  localparam int SC = 8;
  localparam int GC = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por = 1'b1;
  logic       ext_hard = 1'b0, ext_soft = 1'b0;
  logic       wdog_zero = 1'b0, wdog_en = 1'b0, bmon_zero = 1'b0, bmon_en = 1'b0;
  logic       host_cmd = 1'b0, clr_we = 1'b0;
  logic [5:0] clr_mask = 6'h00;
  logic       hard_sense, soft_sense;
  logic       hard_drive_en, soft_drive_en, core_rst, cfg_hard_sample, cfg_por_sample;
  logic [5:0] rst_status;

  // open-drain lines: asserted if anyone pulls them
  assign hard_sense = hard_drive_en | ext_hard;
  assign soft_sense = soft_drive_en | ext_soft;

  rst_seq_ctrl #(.HARD_CYC(HC), .SOFT_CYC(SC), .GAP_CYC(GC)) u_dut (
    .clk(clk), .por(por), .hard_sense(hard_sense), .soft_sense(soft_sense),
    .wdog_zero(wdog_zero), .wdog_en(wdog_en), .bmon_zero(bmon_zero), .bmon_en(bmon_en),
    .host_rst_cmd(host_cmd), .sts_clr_we(clr_we), .sts_clr_mask(clr_mask),
    .hard_drive_en(hard_drive_en), .soft_drive_en(soft_drive_en), .core_rst(core_rst),
    .cfg_hard_sample(cfg_hard_sample), .cfg_por_sample(cfg_por_sample),
    .rst_status(rst_status));

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_hl = HC, m_gl = GC, m_sl = 0, m_cls = 3;
  logic [5:0] m_sts = 6'b000001;
  bit         started = 0;

  always @(posedge clk) begin : model
    logic [5:0] hsrc;
    logic [5:0] ssrc;
    started = 1;
    if (por) begin
      m_cls = 3; m_hl = HC; m_gl = GC; m_sl = 0; m_sts = 6'b000001;
    end else begin
      hsrc = 6'b0;
      ssrc = 6'b0;
      hsrc[1] = ext_hard && (m_hl == 0);
      hsrc[3] = wdog_zero && wdog_en;
      hsrc[4] = bmon_zero && bmon_en;
      ssrc[2] = ext_soft;
      ssrc[5] = host_cmd;
      if (clr_we) m_sts = m_sts & ~clr_mask;
      if (m_cls < 2 && hsrc != 0) begin
        m_cls = 2; m_hl = HC; m_gl = GC; m_sl = 0; m_sts = m_sts | hsrc;
      end else if (m_cls == 0 && ssrc != 0) begin
        m_cls = 1; m_sl = SC; m_sts = m_sts | ssrc;
      end else begin
        if (m_hl > 0) m_hl--;
        else if (m_gl > 0) m_gl--;
        else if (m_sl > 0) m_sl--;
        if (m_hl + m_gl + m_sl == 0) m_cls = 0;
      end
    end
  end

  // ---------------- per-cycle compare and monitors ----------------
  int mon_hard = 0, mon_soft = 0, mon_psmp = 0, mon_hsmp = 0;

  always @(negedge clk) begin
    if (started) begin
      chk("R2 hard_drive_en vs model", int'(hard_drive_en), int'(m_hl > 0));
      chk("R10 soft_drive_en vs model", int'(soft_drive_en), int'((m_hl + m_gl + m_sl) > 0));
      chk("R5 core_rst vs model", int'(core_rst), int'((m_hl + m_gl + m_sl) > 0));
      chk("R4 cfg_hard_sample vs model", int'(cfg_hard_sample), int'(m_cls >= 2 && m_hl == HC - 1));
      chk("R3 cfg_por_sample vs model", int'(cfg_por_sample), int'(m_cls == 3 && m_hl == HC - 1));
      chk("R11 rst_status vs model", int'(rst_status), int'(m_sts));
    end
    mon_hard += int'(hard_drive_en);
    mon_soft += int'(soft_drive_en);
    mon_psmp += int'(cfg_por_sample);
    mon_hsmp += int'(cfg_hard_sample);
  end

  task automatic clear_mon();
    @(posedge clk);
    #1;
    mon_hard = 0; mon_soft = 0; mon_psmp = 0; mon_hsmp = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 6'h3F;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = 6'h00;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: state while power-on is held
    tick(5);
    chk("R1 hard during por", int'(hard_drive_en), 1);
    chk("R1 soft during por", int'(soft_drive_en), 1);
    chk("R1 core during por", int'(core_rst), 1);
    chk("R1 status during por", int'(rst_status), 1);

    // R2 R3 R4: power-on flow
    clear_mon();
    @(negedge clk); por = 1'b0;
    tick(40);
    chk("R2 por hard cycles", mon_hard, HC);
    chk("R2 por soft cycles", mon_soft, HC + GC);
    chk("R3 por sample pulses", mon_psmp, 1);
    chk("R4 hard sample pulses in por", mon_hsmp, 1);

    // R12: write-one-to-clear
    clear_status();
    tick(1);
    chk("R12 status after W1C", int'(rst_status), 0);

    // R5: soft pin while idle
    clear_mon();
    @(negedge clk); ext_soft = 1'b1;
    @(negedge clk); ext_soft = 1'b0;
    tick(20);
    chk("R5 soft cycles", mon_soft, SC);
    chk("R5 no hard", mon_hard, 0);
    chk("R5 no strobe", mon_hsmp + mon_psmp, 0);
    chk("R11 soft pin bit", int'(rst_status), 6'b000100);

    // R6 R8: host command, then soft pin during own flow
    clear_status();
    clear_mon();
    @(negedge clk); host_cmd = 1'b1;
    @(negedge clk); host_cmd = 1'b0;
    tick(2);
    ext_soft = 1'b1;
    @(negedge clk); ext_soft = 1'b0;
    tick(20);
    chk("R8 host soft cycles", mon_soft, SC);
    chk("R6 soft pin ignored status", int'(rst_status), 6'b100000);

    // R7: watchdog disabled, then enabled
    clear_status();
    clear_mon();
    @(negedge clk); wdog_zero = 1'b1; wdog_en = 1'b0;
    @(negedge clk); wdog_zero = 1'b0;
    tick(30);
    chk("R7 disabled watchdog no reset", mon_soft, 0);
    clear_mon();
    @(negedge clk); wdog_zero = 1'b1; wdog_en = 1'b1;
    @(negedge clk); wdog_zero = 1'b0;
    tick(40);
    chk("R7 watchdog hard cycles", mon_hard, HC);
    chk("R7 watchdog soft cycles", mon_soft, HC + GC);
    chk("R3 no por strobe in hard flow", mon_psmp, 0);
    chk("R4 hard strobe in hard flow", mon_hsmp, 1);
    chk("R11 watchdog bit", int'(rst_status), 6'b001000);

    // R9: bus monitor flow, watchdog during hold ignored
    clear_status();
    clear_mon();
    @(negedge clk); bmon_zero = 1'b1; bmon_en = 1'b1;
    @(negedge clk); bmon_zero = 1'b0;
    tick(4);
    wdog_zero = 1'b1;
    @(negedge clk); wdog_zero = 1'b0;
    tick(40);
    chk("R9 hard not extended", mon_hard, HC);
    chk("R9 ignored watchdog not recorded", int'(rst_status), 6'b010000);

    // R9 R13: soft flow restarted by hard pin
    clear_status();
    clear_mon();
    @(negedge clk); host_cmd = 1'b1;
    @(negedge clk); host_cmd = 1'b0;
    tick(2);
    ext_hard = 1'b1;
    @(negedge clk); ext_hard = 1'b0;
    tick(40);
    chk("R9 restart hard cycles", mon_hard, HC);
    chk("R9 restart soft cycles", mon_soft, 3 + HC + GC);
    chk("R4 restart hard strobe", mon_hsmp, 1);
    chk("R13 hard pin status", int'(rst_status), 6'b100010);

    // R11: simultaneous classes, only hard recorded
    clear_status();
    clear_mon();
    @(negedge clk); ext_hard = 1'b1; host_cmd = 1'b1; ext_soft = 1'b1;
    @(negedge clk); ext_hard = 1'b0; host_cmd = 1'b0; ext_soft = 1'b0;
    tick(40);
    chk("R11 only hard source recorded", int'(rst_status), 6'b000010);
    chk("R11 flow was hard", mon_hard, HC);

    // R12: power-on during a flow clears the other bits
    @(negedge clk); bmon_zero = 1'b1;
    @(negedge clk); bmon_zero = 1'b0;
    tick(5);
    por = 1'b1;
    tick(3);
    chk("R12 status after por", int'(rst_status), 6'b000001);
    chk("R1 hard in second por", int'(hard_drive_en), 1);
    por = 1'b0;
    tick(40);
    chk("R2 idle after second por", int'(soft_drive_en), 0);

    finish_run();
  end

endmodule